// File: doc/BRIEF.md
# Serial Byte Transmitter, 8-N-1, with Early Ready

This block turns bytes into a serial line stream. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity bit and no flow control. Two parameters, the clock frequency `CLK_HZ` and the baud rate `BAUD`, set the bit length. It is the whole number of clocks nearest to `CLK_HZ / BAUD`. Elaboration fails if that count is below three clocks. It also fails if the drift summed over a ten-bit frame reaches half a bit.

A host offers a byte by holding `send` high while `ready` is high. On that clock edge the block copies `tx_data` into an internal holding register, so the input only needs to be valid on that one edge. `ready` drops while the start bit and the data bits are on the line. It rises again as soon as the last data bit ends, while the stop bit is still being sent. A byte offered during the stop bit goes out directly after that stop bit, so consecutive frames have no idle time between them.

The controller has four states:
- `ST_IDLE`: the line is high and `ready` is high.
- `ST_START`: the start bit is being sent.
- `ST_DATA`: the data bits are being sent.
- `ST_STOP`: the stop bit is being sent.

Its transitions are:
- idle→start, on an accepted byte.
- start→data, at the end of the start bit.
- data→stop, at the end of the eighth data bit.
- stop→start, at the end of the stop bit when a byte is waiting or arrives on that edge.
- stop→idle, at the end of the stop bit otherwise.

A synchronous reset returns the controller to idle from any state.

Top module: `serial_tx8n1`

## Requirements
- R1: After reset, `txd` is 1 and `ready` is 1, and both stay that way while no byte is offered.
- R2: A frame on `txd` is one bit at 0, then bits 0 to 7 of the byte with bit 0 first, then one bit at 1.
- R3: Every bit of a frame, including the start and stop bits, holds `txd` constant for exactly round(`CLK_HZ`/`BAUD`) clocks. The start bit begins on the clock edge that accepts the byte.
- R4: The byte is taken from `tx_data` on the rising edge where `send` and `ready` are both 1. Later changes on `tx_data` do not alter the frame.
- R5: `ready` is 0 from the accepting edge until the last data bit ends.
- R6: `ready` becomes 1 on the edge where the stop bit starts, and stays 1 during the stop bit until a byte is accepted.
- R7: A byte accepted during the stop bit has its start bit begin on the edge that ends the previous stop bit, with no idle clocks in between.
- R8: `send` while `ready` is 0 is ignored. The running frame is unchanged, and no extra frame follows it.
- R9: `rst` held high for one rising edge returns the block to idle (`txd` 1, `ready` 1) from any point in a frame. A byte can be accepted on the first edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | 8 | Byte to send, sampled on the accepting edge |
| send | input | 1 | Request to send `tx_data` |
| ready | output | 1 | High when a byte can be accepted |
| txd | output | 1 | Serial line output, idles high |

## Verification
The embedded properties check several rules on every clock:
- the line goes low and `ready` drops on the clock after an accept;
- `txd` never changes inside a bit period;
- the bit counter stays within the bit length;
- `ready` only rises while the line is high;
- a byte is never loaded over one that is still waiting;
- reset always lands in idle.

Other behaviour can only be shown by the directed scenarios, because each needs a whole frame compared against the byte that was offered:
- the bit order and data values;
- the exact bit count and frame length;
- gapless back-to-back frames;
- immunity to `tx_data` changes and to strobes while busy;
- recovery from a reset in mid-frame.

// File: rtl/txu_pkg.sv
package txu_pkg;

    localparam int DATA_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } txu_state_e;

    // Nearest whole number of clocks per bit.
    function automatic longint bit_cycles(input longint clk_hz, input longint baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/txu_bit_timer.sv
module txu_bit_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(CYC)); // R3

endmodule

// File: rtl/txu_frame_data.sv
module txu_frame_data #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NB-1:0] tx_data,
    input  logic          start_end,
    input  logic          data_tick,
    output logic          pending,
    output logic          data_bit,
    output logic          last_bit
);
    localparam int IW = $clog2(NB);

    logic [NB-1:0] hold_q;
    logic [NB-1:0] shr_q;
    logic [IW-1:0] idx_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            shr_q  <= '0;
            idx_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (load) begin
                hold_q <= tx_data;
                pend_q <= 1'b1;
            end
            if (start_end) begin
                shr_q  <= hold_q;
                idx_q  <= '0;
                pend_q <= 1'b0;
            end else if (data_tick) begin
                shr_q <= shr_q >> 1;
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    assign pending  = pend_q;
    assign data_bit = shr_q[0];
    assign last_bit = (idx_q == IW'(NB - 1));

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        load |-> !pend_q); // R8

    AST_NO_LOAD_AT_SHIFT: assert property (@(posedge clk) disable iff (rst)
        load |-> !start_end); // R4

endmodule

// File: rtl/txu_ctrl.sv
module txu_ctrl
    import txu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       send,
    input  logic       tick,
    input  logic       pending,
    input  logic       last_bit,
    output txu_state_e state,
    output logic       ready,
    output logic       accept,
    output logic       run
);
    txu_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_START;
            ST_START: if (tick) state_d = ST_DATA;
            ST_DATA:  if (tick && last_bit) state_d = ST_STOP;
            ST_STOP:  if (tick) state_d = (pending || accept) ? ST_START : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready = 1'b0;
        run   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                run   = 1'b0;
            end
            ST_STOP: ready = !pending;
            default: ready = 1'b0;
        endcase
        accept = send && ready;
    end

    assign state = state_q;

    AST_DATA_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && tick && last_bit) |=> (state_q == ST_STOP && ready)); // R6

endmodule

// File: rtl/serial_tx8n1.sv
module serial_tx8n1
    import txu_pkg::*;
#(
    parameter int CLK_HZ = 16000000,
    parameter int BAUD   = 115200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] tx_data,
    input  logic       send,
    output logic       ready,
    output logic       txd
);
    localparam longint BIT_CYC_L  = bit_cycles(longint'(CLK_HZ), longint'(BAUD));
    localparam int     BIT_CYC    = int'(BIT_CYC_L);
    localparam longint DRIFT_RAW  = BIT_CYC_L * BAUD - longint'(CLK_HZ);
    // Frame drift and its limit, both in units of clock periods times BAUD.
    localparam longint FRAME_ERR  = 10 * (DRIFT_RAW < 0 ? -DRIFT_RAW : DRIFT_RAW);
    localparam longint FRAME_LIM  = longint'(CLK_HZ) / 2;

    generate
        if (BIT_CYC < 3) begin : g_rate_bad
            $error("baud rate above one third of the clock");
        end
        if (FRAME_ERR >= FRAME_LIM) begin : g_drift_bad
            $error("clock to baud ratio drifts too far over one frame");
        end
    endgenerate

    txu_state_e state;
    logic tick, run, accept, pending, data_bit, last_bit;

    txu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .send     (send),
        .tick     (tick),
        .pending  (pending),
        .last_bit (last_bit),
        .state    (state),
        .ready    (ready),
        .accept   (accept),
        .run      (run)
    );

    txu_bit_timer #(.CYC(BIT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    txu_frame_data #(.NB(DATA_BITS)) u_data (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .tx_data   (tx_data),
        .start_end (state == ST_START && tick),
        .data_tick (state == ST_DATA && tick),
        .pending   (pending),
        .data_bit  (data_bit),
        .last_bit  (last_bit)
    );

    always_comb begin
        unique case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = data_bit;
            default:  txd = 1'b1;
        endcase
    end

    AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (send && ready) |=> (!txd || state == ST_STOP) && !ready); // R2

    AST_READY_RISE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> txd); // R6

    AST_TXD_STEADY: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && !$past(tick)) |-> $stable(txd)); // R3

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (ready && txd)); // R9

endmodule

// File: tb/serial_tx8n1_test.sv
module serial_tx8n1_test;

    localparam int CLK_HZ = 50000000;
    localparam int BAUD   = 5000000;
    localparam int BC     = 10;      // round(CLK_HZ/BAUD)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       send = 1'b0;
    logic       ready, txd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    serial_tx8n1 #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
        .clk     (clk),
        .rst     (rst),
        .tx_data (tx_data),
        .send    (send),
        .ready   (ready),
        .txd     (txd)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Check n negedges of idle line; called at a negedge, ends at a negedge.
    task automatic check_idle(input int n, input string req);
        bit ok = 1'b1;
        int bt = 1, br = 1;
        for (int i = 0; i < n; i++) begin
            if (txd !== 1'b1 || ready !== 1'b1) begin
                ok = 1'b0; bt = int'(txd); br = int'(ready);
            end
            @(negedge clk);
        end
        check(ok, req, "idle txd", bt, 1);
        check(ok, req, "idle ready", br, 1);
    endtask

    // Offer a byte at the current negedge; returns at the negedge after the
    // accepting edge, with tx_data scrambled (R4).
    task automatic offer(input logic [7:0] d);
        tx_data = d;
        send    = 1'b1;
        @(negedge clk);
        send    = 1'b0;
        tx_data = ~d;
    endtask

    // Watch one frame from the first negedge after its accepting edge.
    // poke: strobe send while busy (R8). nxt: offer next byte in stop bit.
    task automatic watch_frame(input logic [7:0] d, input bit poke,
                               input bit nxt, input logic [7:0] nd);
        bit offered = 1'b0;
        for (int k = 0; k < 10; k++) begin
            bit exp_b = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : d[k-1];
            bit ok_b = 1'b1, ok_r = 1'b1;
            int got_b = int'(exp_b), got_r = 0, exp_r = 0;
            for (int c = 0; c < BC; c++) begin
                bit er = (k == 9) && !offered;
                if (txd !== exp_b) begin ok_b = 1'b0; got_b = int'(txd); end
                if (ready !== er) begin ok_r = 1'b0; got_r = int'(ready); exp_r = int'(er); end
                // drive after sampling
                send = 1'b0;
                if (poke && k == 3 && c == 4) begin
                    send = 1'b1; tx_data = 8'h5A;
                end
                if (nxt && k == 9 && c == 2) begin
                    send = 1'b1; tx_data = nd; offered = 1'b1;
                end else if (offered && k == 9 && c == 3) begin
                    tx_data = ~nd;
                end
                @(negedge clk);
            end
            check(ok_b, (k == 0) ? "R3" : (k == 9) ? "R2" : "R2", $sformatf("bit %0d value/length", k), got_b, int'(exp_b));
            check(ok_r, (k == 9) ? "R6" : "R5", $sformatf("ready in bit %0d", k), got_r, exp_r);
        end
        send = 1'b0;
    endtask

    task automatic t_reset_state();
        check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(ready === 1'b1, "R1", "ready after reset", int'(ready), 1);
        check_idle(20, "R1");
    endtask

    task automatic t_single();
        offer(8'hA5);
        check(txd === 1'b0, "R4", "start on accept edge", int'(txd), 0);
        watch_frame(8'hA5, 1'b0, 1'b0, 8'h00);
        check_idle(15, "R1");
    endtask

    task automatic t_busy_ignored();
        offer(8'h01);
        watch_frame(8'h01, 1'b1, 1'b0, 8'h00);
        check_idle(25, "R8");
    endtask

    task automatic t_back_to_back();
        offer(8'h3C);
        watch_frame(8'h3C, 1'b0, 1'b1, 8'hFF);
        check(txd === 1'b0, "R7", "no gap before 2nd start", int'(txd), 0);
        watch_frame(8'hFF, 1'b0, 1'b1, 8'h00);
        check(txd === 1'b0, "R7", "no gap before 3rd start", int'(txd), 0);
        watch_frame(8'h00, 1'b0, 1'b0, 8'h00);
        check_idle(15, "R7");
    endtask

    task automatic t_reset_mid();
        offer(8'hC3);
        for (int i = 0; i < 35; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(txd === 1'b1, "R9", "txd after mid reset", int'(txd), 1);
        check(ready === 1'b1, "R9", "ready after mid reset", int'(ready), 1);
        rst = 1'b0;
        offer(8'h80);
        check(txd === 1'b0, "R9", "start right after reset", int'(txd), 0);
        watch_frame(8'h80, 1'b0, 1'b0, 8'h00);
        check_idle(10, "R9");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_single();
        t_busy_ignored();
        t_back_to_back();
        t_reset_mid();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule